// File: doc/BRIEF.md
# Nibble-Wide Cell Receiver with Clock-Gap Flow Control

This block sits on the physical-layer side of a point-to-point, 4-bit, cell-oriented link. The upstream source sends a one-cycle start marker, then the 106 nibbles of a 53-byte cell. The block pairs the nibbles into bytes and collects each cell in a small internal buffer. A byte-wide read port drains the buffer in arrival order. The block runs from one free-running clock. Its output `xfer_en` is a per-cycle enable that stands for the rising edges of the clock returned to the sender. A nibble and a marker count as transferred only in a cycle where `xfer_en` is high. The block applies back-pressure by keeping `xfer_en` low, so the sender sees no edges, rather than through a ready/valid handshake.

A framing state machine has three states. `ST_IDLE` waits for a marker. `ST_HI` expects the upper nibble of a byte. `ST_LO` expects the lower nibble, and writes the byte when it arrives. Its transitions are:

- IDLE→HI: a marker arrives.
- HI→HI: a marker arrives again. With no nibble yet, this is a silent restart. With nibbles already received, it is an abort.
- HI→LO: the upper nibble is taken.
- LO→HI: a byte is complete and more bytes of the cell follow.
- LO→IDLE: the last byte of the cell is written.
- LO→HI on the last byte: a marker comes with the final nibble, which allows back-to-back cells.
- LO→HI abort: a marker arrives before the last byte.

Written bytes stay invisible to the reader until the last byte of the cell commits them. An abort rolls the write pointer back to the last commit point.

Top module: `nibble_cell_rx`

## Requirements
- R1: After reset, `cell_avail` is 0, `err_abort` is 0 and `xfer_en` is 1.
- R2: A transfer with `cell_sc`=1 arms the receiver. The next 106 transfers carry one cell: 5 header bytes, then 48 payload bytes.
- R3: The first nibble of each byte lands in bits 7:4 of `rd_byte` and the second nibble in bits 3:0. Bytes come out in the order they arrived.
- R4: `rd_first` is 1 for the first byte of each cell and 0 for the other 52 bytes.
- R5: A marker that comes with the 106th nibble completes the current cell and arms the next one. The next 106 transfers then form a second full cell, and no error is raised.
- R6: `xfer_en` is 0 whenever the buffer holds DEPTH bytes. No nibble is lost during the stall, and transfers resume once bytes are read.
- R7: Transfers with `cell_sc`=0 while idle are dropped. They produce no byte and no error.
- R8: A marker that arrives after at least one nibble of the current cell and before its 106th nibble discards the partial cell and sets `err_abort`. The flag stays 1 until reset, and the new cell is received normally.
- R9: `cell_avail` is 1 only when at least one committed byte of a complete cell is waiting. A partial cell is never visible. `rd_en` while `cell_avail`=0 has no effect.
- R10: A repeated marker before the first nibble of a cell restarts framing and does not set `err_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_sc | input | 1 | Start-of-cell marker, one transfer ahead of the first nibble |
| cell_nib | input | 4 | Nibble from the sender |
| xfer_en | output | 1 | Transfer-clock edge enable; a transfer occurs in cycles where it is 1 |
| rd_en | input | 1 | Pop one byte from the buffer |
| rd_byte | output | 8 | Oldest committed byte |
| rd_first | output | 1 | High when `rd_byte` is the first byte of a cell |
| cell_avail | output | 1 | Committed data is waiting |
| err_abort | output | 1 | Sticky flag: a partial cell was aborted |

## Verification
The hardest state to reach from the ports is a stall in the middle of a cell: the buffer is full and the sender still holds part of a cell. The bench sends two cells without reading, which leaves room for only 22 more bytes. It then starts a third cell in one thread while a second thread watches `xfer_en` stay low for hundreds of cycles before draining one cell. The contents of all three cells are then compared byte for byte, which shows that the stall lost or repeated no nibble. Aborts are provoked in both nibble phases, and back-to-back framing is provoked by raising the marker on the final nibble.

// File: rtl/nibcell_pkg.sv
package nibcell_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } frm_state_t;

    localparam int CELL_BYTES_DEF = 53;
    localparam int NIB_W          = 4;
    localparam int BYTE_W         = 2 * NIB_W;
endpackage

// File: rtl/nibcell_frm.sv
module nibcell_frm
    import nibcell_pkg::*;
#(
    parameter int CELL_BYTES = CELL_BYTES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic              sc,
    input  logic [NIB_W-1:0]  nib,
    output logic              wr_vld,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_first,
    output logic              commit,
    output logic              abort,
    output logic              err_flag
);
    localparam int IW = $clog2(CELL_BYTES);

    frm_state_t       state, nxt_state;
    logic [IW-1:0]    byte_idx, nxt_idx;
    logic [NIB_W-1:0] hi_nib, nxt_hi;
    logic             last;

    assign last = (byte_idx == IW'(CELL_BYTES - 1));

    // next-state decode
    always_comb begin
        nxt_state = state;
        nxt_idx   = byte_idx;
        nxt_hi    = hi_nib;
        if (xfer) begin
            unique case (state)
                ST_IDLE: begin
                    if (sc) begin
                        nxt_state = ST_HI;
                        nxt_idx   = '0;
                    end
                end
                ST_HI: begin
                    if (sc) begin
                        nxt_idx = '0;
                    end else begin
                        nxt_hi    = nib;
                        nxt_state = ST_LO;
                    end
                end
                ST_LO: begin
                    if (last) begin
                        nxt_idx   = '0;
                        nxt_state = sc ? ST_HI : ST_IDLE;
                    end else if (sc) begin
                        nxt_idx   = '0;
                        nxt_state = ST_HI;
                    end else begin
                        nxt_idx   = byte_idx + 1'b1;
                        nxt_state = ST_HI;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
            hi_nib   <= '0;
            err_flag <= 1'b0;
        end else begin
            state    <= nxt_state;
            byte_idx <= nxt_idx;
            hi_nib   <= nxt_hi;
            if (abort) err_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_vld   = 1'b0;
        commit   = 1'b0;
        abort    = 1'b0;
        wr_byte  = {hi_nib, nib};
        wr_first = (byte_idx == '0);
        if (xfer) begin
            unique case (state)
                ST_IDLE: ;
                ST_HI: abort = sc && (byte_idx != '0);
                ST_LO: begin
                    wr_vld = !sc || last;
                    commit = last;
                    abort  = sc && !last;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nibcell_buf.sv
module nibcell_buf
    import nibcell_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wr_first,
    input  logic              commit,
    input  logic              abort,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_first,
    output logic              avail,
    output logic              room,
    output logic [$clog2(DEPTH):0] occ
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [BYTE_W:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, cm_ptr, rd_ptr;
    logic            pop;

    assign pop   = rd_en && avail;
    assign occ   = wr_ptr - rd_ptr;
    assign room  = (occ != PW'(DEPTH));
    assign avail = (cm_ptr != rd_ptr);
    assign {rd_first, rd_byte} = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_vld) mem[wr_ptr[AW-1:0]] <= {wr_first, wr_byte};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (abort)       wr_ptr <= cm_ptr;
            else if (wr_vld) wr_ptr <= wr_ptr + 1'b1;
            if (commit)      cm_ptr <= wr_ptr + 1'b1;
            if (pop)         rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/nibble_cell_rx.sv
module nibble_cell_rx
    import nibcell_pkg::*;
#(
    parameter int CELL_BYTES = CELL_BYTES_DEF,
    parameter int DEPTH      = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_sc,
    input  logic [NIB_W-1:0] cell_nib,
    output logic             xfer_en,
    input  logic             rd_en,
    output logic [7:0]       rd_byte,
    output logic             rd_first,
    output logic             cell_avail,
    output logic             err_abort
);
    localparam int PW = $clog2(DEPTH) + 1;

    logic              wr_vld, wr_first, commit, abort_p;
    logic [BYTE_W-1:0] wr_byte;
    logic [PW-1:0]     occ;

    nibcell_frm #(.CELL_BYTES(CELL_BYTES)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer_en),
        .sc       (cell_sc),
        .nib      (cell_nib),
        .wr_vld   (wr_vld),
        .wr_byte  (wr_byte),
        .wr_first (wr_first),
        .commit   (commit),
        .abort    (abort_p),
        .err_flag (err_abort)
    );

    nibcell_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (wr_vld),
        .wr_byte  (wr_byte),
        .wr_first (wr_first),
        .commit   (commit),
        .abort    (abort_p),
        .rd_en    (rd_en),
        .rd_byte  (rd_byte),
        .rd_first (rd_first),
        .avail    (cell_avail),
        .room     (xfer_en),
        .occ      (occ)
    );
endmodule

// File: rtl/nibcell_chk.sv
module nibcell_chk #(
    parameter int DEPTH = 128,
    parameter int PW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_en,
    input logic          rd_en,
    input logic          cell_avail,
    input logic          err_abort,
    input logic          abort_p,
    input logic [PW-1:0] occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH)); // R6

    AST_NO_GROWTH_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> occ <= $past(occ)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_abort |=> err_abort); // R8

    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> err_abort); // R8

    AST_AVAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_avail && !rd_en) |=> cell_avail); // R9
endmodule

bind nibble_cell_rx nibcell_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_en    (xfer_en),
    .rd_en      (rd_en),
    .cell_avail (cell_avail),
    .err_abort  (err_abort),
    .abort_p    (abort_p),
    .occ        (occ)
);

// File: tb/nibble_cell_rx_tb.sv
`timescale 1ns/1ps
module nibble_cell_rx_tb;
    localparam int NB = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cell_sc = 1'b0;
    logic [3:0] cell_nib = '0;
    logic       rd_en = 1'b0;
    logic       xfer_en, rd_first, cell_avail, err_abort;
    logic [7:0] rd_byte;

    int nchk = 0;
    int nerr = 0;
    bit stall_done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_cell_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cell_sc(cell_sc), .cell_nib(cell_nib),
        .xfer_en(xfer_en), .rd_en(rd_en), .rd_byte(rd_byte),
        .rd_first(rd_first), .cell_avail(cell_avail), .err_abort(err_abort)
    );

    function automatic logic [7:0] byte_at(input int c, input int i);
        int v;
        v = c * 37 + i * 11 + 5;
        return 8'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // present one transfer; hold until an enabled edge takes it
    task automatic push(input logic sc, input logic [3:0] nib);
        bit took;
        cell_sc  = sc;
        cell_nib = nib;
        do begin
            took = xfer_en;
            @(negedge clk);
        end while (!took);
        cell_sc  = 1'b0;
    endtask

    task automatic send_cell(input int c, input bit lead_sc, input bit tail_sc);
        logic [7:0] b;
        if (lead_sc) push(1'b1, 4'h0);
        for (int i = 0; i < NB; i++) begin
            b = byte_at(c, i);
            push(1'b0, b[7:4]);
            push((i == NB - 1) ? tail_sc : 1'b0, b[3:0]);
        end
    endtask

    task automatic read_cell(input int c, input string tag);
        int bad_d = 0;
        int bad_f = 0;
        for (int i = 0; i < NB; i++) begin
            while (!cell_avail) @(negedge clk);
            if (rd_byte != byte_at(c, i)) bad_d++;
            if (rd_first != (i == 0)) bad_f++;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(bad_d == 0, {"R3 data ", tag}, bad_d, 0);
        chk(bad_f == 0, {"R4 first-flag ", tag}, bad_f, 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cell_avail == 1'b0, "R1 cell_avail", cell_avail, 0);
        chk(err_abort == 1'b0, "R1 err_abort", err_abort, 0);
        chk(xfer_en == 1'b1, "R1 xfer_en", xfer_en, 1);

        // R9 pop on empty ignored
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        // R7 idle nibbles dropped
        for (int k = 0; k < 10; k++) push(1'b0, 4'(k + 3));
        chk(cell_avail == 1'b0, "R7 no data from idle nibbles", cell_avail, 0);
        chk(err_abort == 1'b0, "R7 no error from idle nibbles", err_abort, 0);

        // R10 repeated marker before first nibble
        push(1'b1, 4'h0);
        send_cell(1, 1'b1, 1'b0);
        chk(err_abort == 1'b0, "R10 no error on double marker", err_abort, 0);
        read_cell(1, "R2 cell1");
        chk(cell_avail == 1'b0, "R9 empty after drain", cell_avail, 0);

        // R9 partial cell invisible
        begin
            logic [7:0] b;
            push(1'b1, 4'h0);
            for (int n = 0; n < 2 * NB - 1; n++) begin
                b = byte_at(2, n / 2);
                push(1'b0, (n % 2 == 0) ? b[7:4] : b[3:0]);
            end
            chk(cell_avail == 1'b0, "R9 hidden before 106th nibble", cell_avail, 0);
            b = byte_at(2, NB - 1);
            push(1'b0, b[3:0]);
            chk(cell_avail == 1'b1, "R9 visible after 106th nibble", cell_avail, 1);
        end
        read_cell(2, "R2 cell2");

        // R5 back-to-back framing
        send_cell(3, 1'b1, 1'b1);
        send_cell(4, 1'b0, 1'b0);
        chk(err_abort == 1'b0, "R5 no error back-to-back", err_abort, 0);
        read_cell(3, "R5 cellA");
        read_cell(4, "R5 cellB");

        // R6 stall while buffer full mid-cell
        send_cell(5, 1'b1, 1'b0);
        send_cell(6, 1'b1, 1'b0);
        fork
            begin
                send_cell(7, 1'b1, 1'b0);
                stall_done = 1'b1;
            end
            begin
                repeat (300) @(negedge clk);
                chk(xfer_en == 1'b0, "R6 gated when full", xfer_en, 0);
                chk(stall_done == 1'b0, "R6 sender held", stall_done, 0);
                read_cell(5, "R6 cell5");
            end
        join
        read_cell(6, "R6 cell6");
        read_cell(7, "R6 cell7 no loss");

        // sweep of patterns, alternating framing styles
        for (int c = 10; c < 18; c++) begin
            send_cell(c, 1'b1, (c % 2) == 0);
            if (c % 2 == 0) begin
                send_cell(c + 100, 1'b0, 1'b0);
                read_cell(c, "R2 sweep");
                read_cell(c + 100, "R5 sweep");
            end else begin
                read_cell(c, "R2 sweep");
            end
        end
        chk(err_abort == 1'b0, "R8 no spurious error", err_abort, 0);

        // R8 abort in low-nibble phase (after 41 nibbles)
        push(1'b1, 4'h0);
        for (int n = 0; n < 41; n++) push(1'b0, 4'(n));
        send_cell(8, 1'b1, 1'b0);
        chk(err_abort == 1'b1, "R8 abort sets flag", err_abort, 1);
        // R8 abort in high-nibble phase (after 40 nibbles)
        push(1'b1, 4'h0);
        for (int n = 0; n < 40; n++) push(1'b0, 4'(15 - n % 16));
        send_cell(9, 1'b1, 1'b0);
        read_cell(8, "R8 cell after abort");
        read_cell(9, "R8 cell after abort 2");
        chk(cell_avail == 1'b0, "R8 partial discarded", cell_avail, 0);
        repeat (20) @(negedge clk);
        chk(err_abort == 1'b1, "R8 flag sticky", err_abort, 1);

        summary();
        $finish;
    end
endmodule